// File: doc/BRIEF.md
# Unaligned Doubleword Load Aligner

This block fetches a 64-bit value that may start at any byte address of a local memory whose only access width is an aligned 16-byte line. A caller presents a byte address with a valid/ready handshake. The block reads the line that holds the address, then the line after it, because an eight-byte value that starts late in a line continues into the next one.

From the four low address bits the block builds one select index per result byte: the offset plus the lane number. Each index picks one byte out of the 32-byte concatenation of the two lines, and the eight picked bytes form the leading slot of the result. The value is held on a response port until the caller acknowledges it. After that the block is idle and takes the next request.

Memory lines are big-endian in this block: line byte 0 is `memRdData[127:120]`, and byte 15 is `memRdData[7:0]`. The read port returns data on the cycle after the read strobe.

Top module: `dword_line_aligner`

## Requirements
- R1: While reset is asserted and after it is released with no request, `reqReady` is 1, `rspValid` is 0 and `memRdEn` is 0.
- R2: A request is accepted only on a rising edge where `reqValid` and `reqReady` are both 1. `reqReady` stays 0 from the accepting edge until the edge where the response is acknowledged.
- R3: After an accepting edge, `memRdEn` is 1 for exactly two consecutive cycles. The first cycle issues line `reqAddr >> 4`, and the second issues that line plus one.
- R4: The second line index wraps modulo the number of lines (2^(ADDR_W-4)). A load at the last line therefore reads line 0 as its second line.
- R5: Count the accepting edge as edge 1. `rspValid` is 0 after edge 3 and becomes 1 after edge 4.
- R6: With offset o = `reqAddr[3:0]`, result byte i (i = 0..7) equals byte o+i of the 32-byte sequence {first line bytes 0..15, second line bytes 0..15}. Result byte 0 is `rspData[63:56]`.
- R7: For offsets 0 to 8, all eight bytes come from the first line. For offsets 9 to 15, the top bytes come from the first line and the rest from the second line, with no gap between them.
- R8: While `rspValid` is 1 and `rspReady` is 0, `rspValid` stays 1 and `rspData` stays unchanged.
- R9: `reqValid` and `reqAddr` are ignored while the block is busy. A request held during a load starts no extra line reads and yields no extra response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Caller presents a load address |
| reqReady | output | 1 | Block is idle and takes a request |
| reqAddr | input | ADDR_W | Byte address of the 64-bit value |
| memRdEn | output | 1 | Line read strobe |
| memRdLine | output | ADDR_W-4 | Index of the aligned line being read |
| memRdData | input | 128 | Line data, one cycle after the strobe, byte 0 in the top bits |
| rspValid | output | 1 | Extracted value is present |
| rspReady | input | 1 | Caller takes the value |
| rspData | output | 64 | Extracted value, lowest-addressed byte in the top bits |

## Verification
The bench sweeps every offset 0 to 15, with weight on 8 and 9, where the value first crosses a line boundary. A design with an off-by-one in the select index, or one that reads only one line, returns stale or shifted bytes there. Loads at the top line test the line wrap: a second read that carries past the memory end, or stays on the same line, shows up as a wrong line index or as wrong trailing bytes. Back-pressure on the response, and a request kept asserted during a load, expose a response that drifts before it is acknowledged and a busy block that still starts reads.

// File: rtl/dword_line_aligner_pkg.sv
package dword_line_aligner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RDLO  = 3'd1,
    ST_RDHI  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_RESP  = 3'd4
  } alignState_e;

  // Control to datapath strobes
  typedef struct packed {
    logic captureReq;  // latch address on acceptance
    logic issueLo;     // first line read on the port
    logic issueHi;     // second line read on the port
    logic captureLo;   // first line data is on memRdData
    logic captureHi;   // second line data is on memRdData
  } alignStrb_t;

endpackage

// File: rtl/dword_line_aligner_ctrl.sv
module dword_line_aligner_ctrl
  import dword_line_aligner_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       memRdEn,
  output logic       rspValid,
  input  logic       rspReady,
  output alignStrb_t strb
);

  alignState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    reqReady  = 1'b0;
    memRdEn   = 1'b0;
    rspValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.captureReq = 1'b1;
          stateNext       = ST_RDLO;
        end
      end
      ST_RDLO: begin
        memRdEn      = 1'b1;
        strb.issueLo = 1'b1;
        stateNext    = ST_RDHI;
      end
      ST_RDHI: begin
        memRdEn        = 1'b1;
        strb.issueHi   = 1'b1;
        strb.captureLo = 1'b1;
        stateNext      = ST_WAIT;
      end
      ST_WAIT: begin
        strb.captureHi = 1'b1;
        stateNext      = ST_RESP;
      end
      ST_RESP: begin
        rspValid = 1'b1;
        if (rspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R3: the second read follows the first on the next cycle
  assert_rd_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && strb.issueLo) |=> (memRdEn && strb.issueHi));

  // R5: one idle cycle after the second read, then the response
  assert_rsp_timing_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueHi |=> (!rspValid ##1 rspValid));

  // R8: the response is held until acknowledged
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid);

  // R2: no acceptance while a response is pending
  assert_busy_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  // R9: no read strobe outside the two read cycles
  assert_no_stray_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady || rspValid) |-> !memRdEn);

endmodule

// File: rtl/dword_line_aligner_dp.sv
module dword_line_aligner_dp
  import dword_line_aligner_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 16,
  parameter int DATA_W     = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  alignStrb_t         strb,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [LINE_AW-1:0] memRdLine,
  input  logic [LINE_W-1:0]  memRdData,
  input  logic               rspValid,
  input  logic               rspReady,
  output logic [DATA_W-1:0]  rspData
);

  localparam int LANES  = DATA_W / 8;
  localparam int CAT_B  = 2 * LINE_BYTES;
  localparam int PAT_W  = OFF_W + 1;

  logic [LINE_AW-1:0] baseLine;
  logic [OFF_W-1:0]   byteOffset;
  logic [LINE_W-1:0]  loLine, hiLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLine   <= '0;
      byteOffset <= '0;
      loLine     <= '0;
      hiLine     <= '0;
    end else begin
      if (strb.captureReq) begin
        baseLine   <= reqAddr[ADDR_W-1:OFF_W];
        byteOffset <= reqAddr[OFF_W-1:0];
      end
      if (strb.captureLo) loLine <= memRdData;
      if (strb.captureHi) hiLine <= memRdData;
    end
  end

  // Second line index wraps by the natural width of the line address
  assign memRdLine = strb.issueHi ? baseLine + LINE_AW'(1) : baseLine;

  // Byte view of the two-line concatenation, byte 0 = first line byte 0
  logic [7:0] catByte [CAT_B];
  for (genvar j = 0; j < LINE_BYTES; j++) begin : g_cat
    assign catByte[j]              = loLine[LINE_W-1-8*j -: 8];
    assign catByte[j + LINE_BYTES] = hiLine[LINE_W-1-8*j -: 8];
  end

  // Select pattern: offset replicated per lane plus lane index
  logic [PAT_W-1:0] selPat [LANES];
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign selPat[i] = {1'b0, byteOffset} + PAT_W'(i);
    assign rspData[DATA_W-1-8*i -: 8] = catByte[selPat[i]];
  end

  // R4: second line index is one above the first, modulo the line count
  assert_line_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueHi |-> (memRdLine == $past(memRdLine) + LINE_AW'(1)));

  // R8: held response data does not change
  assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> $stable(rspData));

  // R3: first line data is captured one cycle after its read
  assert_capture_lo_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureLo |-> $past(strb.issueLo));

  // R6: lane 0 of the pattern is the raw offset
  assert_pattern_base_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> (selPat[0] == PAT_W'($past(reqAddr[OFF_W-1:0], 4))));

endmodule

// File: rtl/dword_line_aligner.sv
module dword_line_aligner
  import dword_line_aligner_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_BYTES = 16,
  parameter int DATA_W     = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_AW   = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               memRdEn,
  output logic [LINE_AW-1:0] memRdLine,
  input  logic [LINE_W-1:0]  memRdData,
  output logic               rspValid,
  input  logic               rspReady,
  output logic [DATA_W-1:0]  rspData
);

  alignStrb_t strb;

  dword_line_aligner_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .memRdEn  (memRdEn),
    .rspValid (rspValid),
    .rspReady (rspReady),
    .strb     (strb)
  );

  dword_line_aligner_dp #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .DATA_W     (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .memRdLine (memRdLine),
    .memRdData (memRdData),
    .rspValid  (rspValid),
    .rspReady  (rspReady),
    .rspData   (rspData)
  );

endmodule

// File: tb/dword_line_aligner_tb_top.sv
module dword_line_aligner_tb_top;

  localparam int ADDR_W    = 12;
  localparam int MEM_BYTES = 1 << ADDR_W;
  localparam int LINE_AW   = ADDR_W - 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               reqValid = 1'b0;
  logic               reqReady;
  logic [ADDR_W-1:0]  reqAddr = '0;
  logic               memRdEn;
  logic [LINE_AW-1:0] memRdLine;
  logic [127:0]       memRdData = '0;
  logic               rspValid;
  logic               rspReady = 1'b0;
  logic [63:0]        rspData;

  int errors = 0;
  int checks = 0;
  int loads  = 0;
  int reads  = 0;
  int negCnt = 0;
  int readyMode = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [63:0]        expData [$];
  logic [LINE_AW-1:0] expLine [$];

  always #4 clk = ~clk;  // 125 MHz

  dword_line_aligner #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .memRdEn(memRdEn), .memRdLine(memRdLine),
    .memRdData(memRdData), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData)
  );

  function automatic logic [7:0] byteAt(int a);
    int m = a % MEM_BYTES;
    return 8'((m * 37) + ((m >> 5) * 11) + 5);
  endfunction

  function automatic logic [127:0] lineAt(int ln);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[127-8*b -: 8] = byteAt(ln * 16 + b);
    return d;
  endfunction

  function automatic logic [63:0] dwordAt(int a);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[63-8*i -: 8] = byteAt(a + i);
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: one cycle read latency
  always @(posedge clk) if (memRdEn) memRdData <= lineAt(int'(memRdLine));

  // Read monitor (R3, R4)
  always @(negedge clk) begin
    if (running && memRdEn) begin
      reads++;
      if (expLine.size() == 0)
        check(1'b0, "R9", "unexpected line read", 128'(memRdLine), 0);
      else begin
        automatic logic [LINE_AW-1:0] e = expLine.pop_front();
        check(memRdLine == e, "R3/R4", "line index", 128'(memRdLine), 128'(e));
      end
    end
  end

  // Response monitor and back-pressure (R6, R7, R8)
  logic        heldPrev = 1'b0;
  logic [63:0] heldData = '0;
  always @(negedge clk) begin
    negCnt++;
    rspReady = (readyMode == 0) ? 1'b1 : ((negCnt % 3) == 0);
    if (running) begin
      if (heldPrev) begin
        check(rspValid == 1'b1, "R8", "valid dropped before ack", 128'(rspValid), 1);
        check(rspData == heldData, "R8", "data drift", 128'(rspData), 128'(heldData));
      end
      heldPrev = rspValid && !rspReady;
      heldData = rspData;
      if (rspValid && rspReady) begin
        if (expData.size() == 0)
          check(1'b0, "R9", "unexpected response", 128'(rspData), 0);
        else begin
          automatic logic [63:0] e = expData.pop_front();
          check(rspData == e, "R6/R7", "dword", 128'(rspData), 128'(e));
        end
      end
    end
  end

  // Driver: one load, with optional request held asserted while busy
  task automatic doLoad(input int addr, input bit jam);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = ADDR_W'(addr);
    expData.push_back(dwordAt(addr));
    expLine.push_back(LINE_AW'(addr >> 4));
    expLine.push_back(LINE_AW'((addr >> 4) + 1));
    loads++;
    @(posedge clk);            // edge 1: accept
    @(negedge clk);
    reqValid = jam;
    reqAddr  = ~ADDR_W'(addr);
    check(reqReady == 1'b0, "R2", "ready while busy", 128'(reqReady), 0);
    @(posedge clk); @(negedge clk);   // after edge 2
    check(reqReady == 1'b0, "R2", "ready while reading", 128'(reqReady), 0);
    @(posedge clk); @(negedge clk);   // after edge 3
    check(rspValid == 1'b0, "R5", "early response", 128'(rspValid), 0);
    reqValid = 1'b0;
    @(posedge clk); @(negedge clk);   // after edge 4
    check(rspValid == 1'b1, "R5", "response late", 128'(rspValid), 1);
    while (rspValid) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R5 watchdog actual=hang expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lcg = 12345;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready in reset", 128'(reqReady), 1);
    check(rspValid == 1'b0, "R1", "valid in reset", 128'(rspValid), 0);
    check(memRdEn == 1'b0, "R1", "read in reset", 128'(memRdEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqReady == 1'b1 && !rspValid && !memRdEn, "R1", "idle after reset",
          {reqReady, rspValid, memRdEn}, 3'b100);
    running = 1'b1;

    // R7: every offset in one line, then straddling cases
    for (int o = 0; o < 16; o++) doLoad(32 + o, 1'b0);
    doLoad(8, 1'b0);
    doLoad(9, 1'b0);
    // R4: last line, with and without a straddle
    doLoad(MEM_BYTES - 16, 1'b0);
    doLoad(MEM_BYTES - 3, 1'b0);
    doLoad(MEM_BYTES - 8, 1'b0);
    // R9: request kept asserted during busy period
    doLoad(100, 1'b1);
    doLoad(MEM_BYTES - 1, 1'b1);
    // R8: back-pressure on the response
    readyMode = 1;
    for (int k = 0; k < 20; k++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      doLoad(lcg % MEM_BYTES, k[0]);
    end
    readyMode = 0;
    for (int k = 0; k < 20; k++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      doLoad(lcg % MEM_BYTES, 1'b0);
    end
    repeat (6) @(negedge clk);
    check(expData.size() == 0, "R6", "responses missing", 128'(expData.size()), 0);
    check(reads == 2 * loads, "R9", "read count", 128'(reads), 128'(2 * loads));
    check(reqReady == 1'b1 && !memRdEn, "R9", "idle at end",
          {reqReady, memRdEn}, 2'b10);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule